// File: doc/BRIEF.md
# Control-IN Single-Packet Transmit Buffer

This block holds one outgoing data packet for the IN direction of a USB device's control endpoint. Firmware loads up to eight bytes through a byte-wide write port. It then pulses a commit trigger, and only after that does the packet become visible to the serial engine. The engine reads the bytes one at a time and reports how the host responded.

A host ACK releases the buffer and raises a sticky transmit-complete flag, which firmware clears with a write-one-to-clear strobe. A NAK or a timeout keeps the packet committed and rewinds the read pointer, so the same bytes go out again. A flush input empties the buffer at any time and takes priority over every other event in the same cycle. Writes that cannot be accepted are dropped and set a sticky overflow bit.

Top module: `ctrlInTxBuf`

## Requirements
- R1: After reset, pktReady, txValid, txDoneFlag and ovfFlag are 0, and txCount is 0.
- R2: While no packet is committed, each wrEn stores wrData at the next position in write order and increments txCount. Once 8 bytes are held, a further wrEn is dropped, leaves txCount at 8 and sets ovfFlag.
- R3: pktReady rises only in the cycle after a pktTrig that arrives while no packet is committed. A commit with txCount 0 (a zero-length packet) is allowed, and txValid then stays 0.
- R4: While committed, txData shows the byte at the read position, starting with the first byte written. Each txRdEn moves to the next byte. txValid is 1 exactly while bytes remain to be read.
- R5: hostNak on a committed packet keeps pktReady at 1 and keeps txCount. It returns the read position to the first byte.
- R6: hostAck on a committed packet clears pktReady, sets txCount to 0 and sets txDoneFlag. hostAck or hostNak with no committed packet has no effect.
- R7: wrEn while a packet is committed is dropped, so the stored bytes and txCount are unchanged, and it sets ovfFlag.
- R8: txDoneFlag stays 1 until a flagClr pulse clears it. If an ACK sets the flag in the same cycle as flagClr, the flag ends at 1.
- R9: fifoClr empties the buffer: pktReady becomes 0, txCount becomes 0 and ovfFlag becomes 0. It overrides pktTrig, hostAck and wrEn in the same cycle, so an ACK in that cycle does not set txDoneFlag.
- R10: A wrEn in the same cycle as the committing pktTrig is stored and included in txCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Firmware byte write strobe |
| wrData | input | 8 | Byte to store |
| pktTrig | input | 1 | Commit the loaded bytes as a packet |
| fifoClr | input | 1 | Flush the buffer |
| flagClr | input | 1 | Write-one-to-clear for txDoneFlag |
| txRdEn | input | 1 | Serial engine advances to the next byte |
| hostAck | input | 1 | Host acknowledged the packet |
| hostNak | input | 1 | Host refused the packet or timed out |
| txData | output | 8 | Byte at the read position |
| txValid | output | 1 | Committed bytes remain to be read |
| pktReady | output | 1 | A packet is committed |
| txCount | output | 4 | Bytes in the buffer |
| txDoneFlag | output | 1 | Sticky transmit-complete flag |
| ovfFlag | output | 1 | Sticky dropped-write flag |

## Verification
Two pairs of events can land in the same cycle. The first is flush against ACK. The bench commits a packet, then raises fifoClr and hostAck together, and expects an empty buffer with txDoneFlag still 0. The second is the flag set by an ACK against the firmware clear strobe. The bench raises hostAck and flagClr together and expects the flag to read 1. A commit that coincides with a flush, and a commit that coincides with a byte write, are each judged by pktReady and txCount in the following cycle.

// File: rtl/ctrlInTxPkg.sv
package ctrlInTxPkg;
  // Strobes from control to the datapath, one cycle each
  typedef struct packed {
    logic push;      // store wrData at the write position
    logic rdAdv;     // step the read position
    logic rdRewind;  // return the read position to the first byte
    logic flush;     // empty the buffer (both positions to zero)
  } dpStrobe_t;
endpackage

// File: rtl/ctrlInTxData.sv
module ctrlInTxData
  import ctrlInTxPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [DATA_W-1:0] rdByte
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr[IDX_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.rdRewind)   rdPtr <= '0;
      else if (stb.rdAdv) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdByte = mem[rdPtr[IDX_W-1:0]];

  assert_wr_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= DEPTH_P);
  assert_rd_within_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= wrPtr);
endmodule

// File: rtl/ctrlInTxCtrl.sv
module ctrlInTxCtrl
  import ctrlInTxPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             pktTrig,
  input  logic             fifoClr,
  input  logic             flagClr,
  input  logic             txRdEn,
  input  logic             hostAck,
  input  logic             hostNak,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  output dpStrobe_t        stb,
  output logic             pktReady,
  output logic             txValid,
  output logic             txDoneFlag,
  output logic             ovfFlag
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic wrRoom, ackTake, wrDrop;

  always_comb begin
    wrRoom       = wrPtr < DEPTH_P;
    ackTake      = pktReady && hostAck && !fifoClr;
    wrDrop       = wrEn && !fifoClr && (pktReady || !wrRoom);
    stb.flush    = fifoClr || ackTake;
    stb.push     = wrEn && !pktReady && wrRoom && !fifoClr;
    stb.rdRewind = pktReady && hostNak;
    stb.rdAdv    = pktReady && txRdEn && (rdPtr < wrPtr);
    txValid      = pktReady && (rdPtr < wrPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktReady   <= 1'b0;
      txDoneFlag <= 1'b0;
      ovfFlag    <= 1'b0;
    end else begin
      if (fifoClr || ackTake)        pktReady <= 1'b0;
      else if (!pktReady && pktTrig) pktReady <= 1'b1;

      if (ackTake)      txDoneFlag <= 1'b1;
      else if (flagClr) txDoneFlag <= 1'b0;

      if (fifoClr)     ovfFlag <= 1'b0;
      else if (wrDrop) ovfFlag <= 1'b1;
    end
  end

  assert_hold_when_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pktReady && !fifoClr && !hostAck) |=> ($stable(wrPtr) && pktReady));
  assert_nak_rewind_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pktReady && hostNak && !hostAck && !fifoClr) |=> (pktReady && rdPtr == '0));
  assert_ack_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pktReady && hostAck && !fifoClr) |=> (txDoneFlag && !pktReady && wrPtr == '0));
  assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (!pktReady && wrPtr == '0 && !ovfFlag));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneFlag && !flagClr) |=> txDoneFlag);
endmodule

// File: rtl/ctrlInTxBuf.sv
module ctrlInTxBuf
  import ctrlInTxPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pktTrig,
  input  logic              fifoClr,
  input  logic              flagClr,
  input  logic              txRdEn,
  input  logic              hostAck,
  input  logic              hostNak,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              pktReady,
  output logic [PTR_W-1:0]  txCount,
  output logic              txDoneFlag,
  output logic              ovfFlag
);
  dpStrobe_t        stb;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  ctrlInTxCtrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ctrl_i (
    .clk, .rstN, .wrEn, .pktTrig, .fifoClr, .flagClr, .txRdEn,
    .hostAck, .hostNak, .wrPtr, .rdPtr, .stb, .pktReady, .txValid,
    .txDoneFlag, .ovfFlag
  );

  ctrlInTxData #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) data_i (
    .clk, .rstN, .stb, .wrData, .wrPtr, .rdPtr, .rdByte(txData)
  );

  assign txCount = wrPtr;
endmodule

// File: tb/ctrlInTxBuf_tb_top.sv
module ctrlInTxBuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN, wrEn, pktTrig, fifoClr, flagClr, txRdEn, hostAck, hostNak;
  logic [7:0] wrData, txData;
  logic txValid, pktReady, txDoneFlag, ovfFlag;
  logic [3:0] txCount;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrlInTxBuf dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wrEn = 0; pktTrig = 0; fifoClr = 0; flagClr = 0;
    txRdEn = 0; hostAck = 0; hostNak = 0; wrData = 0;
  endtask

  task automatic wrByte(logic [7:0] d);
    wrEn = 1; wrData = d; cyc(); idle();
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(); idle();
  endtask

  function automatic logic [7:0] pat(int n, int i);
    return 8'((n * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); rstN = 0;
    repeat (3) cyc();
    rstN = 1; cyc();
    chk("R1 pktReady", pktReady, 0);
    chk("R1 txValid", txValid, 0);
    chk("R1 txDoneFlag", txDoneFlag, 0);
    chk("R1 ovfFlag", ovfFlag, 0);
    chk("R1 txCount", txCount, 0);

    // R6: ACK/NAK with nothing committed
    pulse(hostAck);
    chk("R6 stray ack flag", txDoneFlag, 0);
    pulse(hostNak);
    chk("R6 stray nak ready", pktReady, 0);

    // Sweep every length 0..8
    for (int n = 0; n <= DEPTH; n++) begin
      pulse(fifoClr);
      for (int i = 0; i < n; i++) begin
        wrByte(pat(n, i));
        chk("R2 count grows", txCount, i + 1);
      end
      chk("R3 not ready before trig", pktReady, 0);
      pulse(pktTrig);
      chk("R3 ready after trig", pktReady, 1);
      chk("R3 count kept", txCount, n);
      chk("R4 valid", txValid, (n > 0) ? 1 : 0);
      for (int i = 0; i < n; i++) begin
        chk("R4 byte", txData, pat(n, i));
        pulse(txRdEn);
      end
      chk("R4 valid after drain", txValid, 0);
      pulse(hostNak);
      chk("R5 still ready", pktReady, 1);
      chk("R5 count", txCount, n);
      if (n > 0) chk("R5 rewound byte", txData, pat(n, 0));
      chk("R5 valid again", txValid, (n > 0) ? 1 : 0);
      pulse(hostAck);
      chk("R6 freed", pktReady, 0);
      chk("R6 count zero", txCount, 0);
      chk("R6 flag", txDoneFlag, 1);
      cyc();
      chk("R8 sticky", txDoneFlag, 1);
      pulse(flagClr);
      chk("R8 cleared", txDoneFlag, 0);
    end

    // R2 overflow on a full buffer
    pulse(fifoClr);
    for (int i = 0; i < DEPTH; i++) wrByte(pat(9, i));
    chk("R2 no ovf at 8", ovfFlag, 0);
    wrByte(8'hEE);
    chk("R2 count capped", txCount, DEPTH);
    chk("R2 ovf set", ovfFlag, 1);
    pulse(pktTrig);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 extra byte dropped", txData, pat(9, i));
      pulse(txRdEn);
    end

    // R7 write while committed
    pulse(fifoClr);
    chk("R9 ovf cleared", ovfFlag, 0);
    wrByte(8'hA1); wrByte(8'hA2);
    pulse(pktTrig);
    wrByte(8'h55);
    chk("R7 count unchanged", txCount, 2);
    chk("R7 ovf", ovfFlag, 1);
    chk("R7 byte0", txData, 8'hA1);
    pulse(txRdEn);
    chk("R7 byte1", txData, 8'hA2);

    // R9 clear and ACK together
    fifoClr = 1; hostAck = 1; cyc(); idle();
    chk("R9 ready cleared", pktReady, 0);
    chk("R9 count cleared", txCount, 0);
    chk("R9 no flag", txDoneFlag, 0);

    // R9 clear and trigger together
    wrByte(8'h10);
    fifoClr = 1; pktTrig = 1; wrEn = 1; wrData = 8'h20; cyc(); idle();
    chk("R9 trig overridden", pktReady, 0);
    chk("R9 write overridden", txCount, 0);

    // R10 write with trigger
    wrByte(8'h31);
    wrEn = 1; wrData = 8'h32; pktTrig = 1; cyc(); idle();
    chk("R10 ready", pktReady, 1);
    chk("R10 count", txCount, 2);
    pulse(txRdEn);
    chk("R10 last byte", txData, 8'h32);

    // R8 ACK set and W1C together
    hostAck = 1; flagClr = 1; cyc(); idle();
    chk("R8 set wins", txDoneFlag, 1);
    chk("R6 freed by ack", pktReady, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule